// File: doc/BRIEF.md
# Dual-Port Mailbox RAM

This block is a two-port synchronous RAM with a mailbox interrupt scheme on top. Each port, left and right, has its own enable, write strobe, output enable, address, write data, read data and collision busy input. Either port can access any location in any cycle, independently of the other. Each port completes one access per clock.

The two highest addresses serve as mailboxes. The second-highest address is the left port's mailbox. The highest address is the right port's mailbox. When one port writes the other port's mailbox, the other port's active-low interrupt asserts. The receiving port clears its own interrupt by reading its own mailbox with the output enable active. The mailbox bytes are ordinary storage, so software chooses what a message means. A busy input driven by an external collision arbiter freezes the interrupt updates caused by that port's accesses.

The address width defaults to 11 bits, which gives mailboxes at 0x7FE and 0x7FF. A 13-bit build places them at 0x1FFE and 0x1FFF.

Top module: `dpram_mailbox`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, l_int_no and r_int_no are 1 and both read data outputs are 0. Memory contents are not initialised.
- R2: A port access with en=1 and we=1 stores wdata at addr. A location written by one port can be read back by either port.
- R3: A read (en=1, we=0) loads rdata at the next clock edge. In a cycle with no read on a port, that port's rdata holds its value.
- R4: A right-port write to the left mailbox (all address bits 1 except bit 0) with r_busy_i=0 drives l_int_no to 0 at the next edge.
- R5: A left-port read of the left mailbox with l_oe_i=1 and l_busy_i=0 drives l_int_no back to 1 at the next edge, unless a set occurs in the same cycle.
- R6: The right interrupt mirrors R4 and R5. A left-port write to the right mailbox (all address bits 1) sets r_int_no to 0. A right-port read of that mailbox with r_oe_i=1 sets r_int_no back to 1.
- R7: When the busy input of the accessing port is 1, that access does not change any interrupt output. The access still reads or writes memory.
- R8: When a set and a clear of the same interrupt occur in one cycle, the interrupt ends set (0).
- R9: When both ports write the same address in one cycle, the left port's data is stored.
- R10: Mailbox locations keep their data like any other location. A mailbox read with oe=0 returns the data but does not clear the interrupt.
- R11: Both ports may read the same location in one cycle and both get its contents. A read that coincides with a write by the other port to the same address returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_en_i | input | 1 | Left port access enable |
| l_we_i | input | 1 | Left write (1) or read (0) |
| l_oe_i | input | 1 | Left output enable, required for a clearing read |
| l_addr_i | input | ADDR_W | Left address |
| l_wdata_i | input | DATA_W | Left write data |
| l_busy_i | input | 1 | Left collision busy, blocks interrupt updates |
| l_rdata_o | output | DATA_W | Left registered read data |
| l_int_no | output | 1 | Left interrupt, active low |
| r_en_i | input | 1 | Right port access enable |
| r_we_i | input | 1 | Right write (1) or read (0) |
| r_oe_i | input | 1 | Right output enable, required for a clearing read |
| r_addr_i | input | ADDR_W | Right address |
| r_wdata_i | input | DATA_W | Right write data |
| r_busy_i | input | 1 | Right collision busy, blocks interrupt updates |
| r_rdata_o | output | DATA_W | Right registered read data |
| r_int_no | output | 1 | Right interrupt, active low |

## Verification
The bench drives a same-cycle set and clear of one interrupt. A design that gave clear priority would lose that message and leave the interrupt high. The bench issues mailbox accesses while busy is asserted. A design that ignored busy would flip the interrupt, and a design that also blocked the data would return stale data afterwards. It reads a mailbox with the output enable low, which catches a clear that wrongly fires on any read. It also collides two writes on one address, which exposes a design that lets the right port win. Finally, it reads while the other port writes the same address, which exposes a design that forwards the new data.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;
  typedef struct packed {
    logic en;
    logic we;
    logic oe;
    logic busy;
  } port_ctl_t;
endpackage

// File: rtl/dpm_port_dec.sv
`timescale 1ns/1ps
module dpm_port_dec
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter logic [ADDR_W-1:0] OWN_MBOX  = '0,
  parameter logic [ADDR_W-1:0] PEER_MBOX = '1
) (
  input  port_ctl_t         ctl_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              wr_o,
  output logic              rd_o,
  output logic              clr_own_o,
  output logic              set_peer_o
);
  always_comb begin
    wr_o       = ctl_i.en & ctl_i.we;
    rd_o       = ctl_i.en & ~ctl_i.we;
    clr_own_o  = rd_o & ctl_i.oe & ~ctl_i.busy & (addr_i == OWN_MBOX);
    set_peer_o = wr_o & ~ctl_i.busy & (addr_i == PEER_MBOX);
  end
endmodule

// File: rtl/dpm_int_flag.sv
`timescale 1ns/1ps
module dpm_int_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic int_no
);
  logic pend_q;

  // set wins so a new message is never dropped
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_q <= 1'b0;
    else if (set_i)  pend_q <= 1'b1;
    else if (clr_i)  pend_q <= 1'b0;
  end

  assign int_no = ~pend_q;
endmodule

// File: rtl/dpm_mem.sv
`timescale 1ns/1ps
module dpm_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_wr_i,
  input  logic              a_rd_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  input  logic [DATA_W-1:0] a_wdata_i,
  output logic [DATA_W-1:0] a_rdata_o,
  input  logic              b_wr_i,
  input  logic              b_rd_i,
  input  logic [ADDR_W-1:0] b_addr_i,
  input  logic [DATA_W-1:0] b_wdata_i,
  output logic [DATA_W-1:0] b_rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // port a is written last and wins an unarbitrated collision
  always_ff @(posedge clk_i) begin
    if (b_wr_i) mem_q[b_addr_i] <= b_wdata_i;
    if (a_wr_i) mem_q[a_addr_i] <= a_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_rdata_o <= '0;
      b_rdata_o <= '0;
    end else begin
      if (a_rd_i) a_rdata_o <= mem_q[a_addr_i];
      if (b_rd_i) b_rdata_o <= mem_q[b_addr_i];
    end
  end
endmodule

// File: rtl/dpram_mailbox.sv
`timescale 1ns/1ps
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_en_i,
  input  logic              l_we_i,
  input  logic              l_oe_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic [DATA_W-1:0] l_wdata_i,
  input  logic              l_busy_i,
  output logic [DATA_W-1:0] l_rdata_o,
  output logic              l_int_no,
  input  logic              r_en_i,
  input  logic              r_we_i,
  input  logic              r_oe_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic [DATA_W-1:0] r_wdata_i,
  input  logic              r_busy_i,
  output logic [DATA_W-1:0] r_rdata_o,
  output logic              r_int_no
);
  localparam logic [ADDR_W-1:0] MBOX_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MBOX_R = '1;

  port_ctl_t l_ctl, r_ctl;
  logic l_wr, l_rd, l_clr, l_set_peer;
  logic r_wr, r_rd, r_clr, r_set_peer;

  assign l_ctl = '{en: l_en_i, we: l_we_i, oe: l_oe_i, busy: l_busy_i};
  assign r_ctl = '{en: r_en_i, we: r_we_i, oe: r_oe_i, busy: r_busy_i};

  dpm_port_dec #(.ADDR_W(ADDR_W), .OWN_MBOX(MBOX_L), .PEER_MBOX(MBOX_R)) u_dec_l (
    .ctl_i(l_ctl), .addr_i(l_addr_i), .wr_o(l_wr), .rd_o(l_rd),
    .clr_own_o(l_clr), .set_peer_o(l_set_peer)
  );

  dpm_port_dec #(.ADDR_W(ADDR_W), .OWN_MBOX(MBOX_R), .PEER_MBOX(MBOX_L)) u_dec_r (
    .ctl_i(r_ctl), .addr_i(r_addr_i), .wr_o(r_wr), .rd_o(r_rd),
    .clr_own_o(r_clr), .set_peer_o(r_set_peer)
  );

  dpm_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .a_wr_i(l_wr), .a_rd_i(l_rd), .a_addr_i(l_addr_i), .a_wdata_i(l_wdata_i), .a_rdata_o(l_rdata_o),
    .b_wr_i(r_wr), .b_rd_i(r_rd), .b_addr_i(r_addr_i), .b_wdata_i(r_wdata_i), .b_rdata_o(r_rdata_o)
  );

  dpm_int_flag u_int_l (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(r_set_peer), .clr_i(l_clr), .int_no(l_int_no)
  );

  dpm_int_flag u_int_r (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(l_set_peer), .clr_i(r_clr), .int_no(r_int_no)
  );
endmodule

// File: rtl/dpm_mailbox_chk.sv
`timescale 1ns/1ps
module dpm_mailbox_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              l_en_i,
  input logic              l_we_i,
  input logic              l_oe_i,
  input logic [ADDR_W-1:0] l_addr_i,
  input logic              l_busy_i,
  input logic [DATA_W-1:0] l_rdata_o,
  input logic              l_int_no,
  input logic              r_en_i,
  input logic              r_we_i,
  input logic              r_oe_i,
  input logic [ADDR_W-1:0] r_addr_i,
  input logic              r_busy_i,
  input logic [DATA_W-1:0] r_rdata_o,
  input logic              r_int_no
);
  localparam logic [ADDR_W-1:0] MB_L = {{(ADDR_W-1){1'b1}}, 1'b0};
  localparam logic [ADDR_W-1:0] MB_R = '1;

  logic set_l, clr_l, set_r, clr_r;
  assign set_l = r_en_i && r_we_i && !r_busy_i && (r_addr_i == MB_L);
  assign clr_l = l_en_i && !l_we_i && l_oe_i && !l_busy_i && (l_addr_i == MB_L);
  assign set_r = l_en_i && l_we_i && !l_busy_i && (l_addr_i == MB_R);
  assign clr_r = r_en_i && !r_we_i && r_oe_i && !r_busy_i && (r_addr_i == MB_R);

  // R3
  l_rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_en_i && !l_we_i) |=> $stable(l_rdata_o));
  // R3
  r_rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(r_en_i && !r_we_i) |=> $stable(r_rdata_o));
  // R4 R8
  l_int_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_l |=> !l_int_no);
  // R5
  l_int_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_l && !set_l) |=> l_int_no);
  // R6
  r_int_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_r |=> !r_int_no);
  // R6
  r_int_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_r && !set_r) |=> r_int_no);
  // R7
  l_int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_l && !clr_l) |=> $stable(l_int_no));
  // R7
  r_int_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_r && !clr_r) |=> $stable(r_int_no));
endmodule

bind dpram_mailbox dpm_mailbox_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_en_i(l_en_i), .l_we_i(l_we_i), .l_oe_i(l_oe_i), .l_addr_i(l_addr_i),
  .l_busy_i(l_busy_i), .l_rdata_o(l_rdata_o), .l_int_no(l_int_no),
  .r_en_i(r_en_i), .r_we_i(r_we_i), .r_oe_i(r_oe_i), .r_addr_i(r_addr_i),
  .r_busy_i(r_busy_i), .r_rdata_o(r_rdata_o), .r_int_no(r_int_no)
);

// File: tb/dpram_mailbox_bench.sv
`timescale 1ns/1ps
module dpram_mailbox_bench;
  localparam int AW = 11;
  localparam logic [AW-1:0] MBL = 11'h7FE;
  localparam logic [AW-1:0] MBR = 11'h7FF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic l_en = 0, l_we = 0, l_oe = 0, l_busy = 0;
  logic r_en = 0, r_we = 0, r_oe = 0, r_busy = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic l_int_n, r_int_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    bit port;
    logic [7:0] data;
    int due;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dpram_mailbox #(.ADDR_W(AW), .DATA_W(8)) u_dpram_mailbox (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_en_i(l_en), .l_we_i(l_we), .l_oe_i(l_oe), .l_addr_i(l_addr), .l_wdata_i(l_wdata),
    .l_busy_i(l_busy), .l_rdata_o(l_rdata), .l_int_no(l_int_n),
    .r_en_i(r_en), .r_we_i(r_we), .r_oe_i(r_oe), .r_addr_i(r_addr), .r_wdata_i(r_wdata),
    .r_busy_i(r_busy), .r_rdata_o(r_rdata), .r_int_no(r_int_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // kind: 0 idle, 1 write, 2 read with oe, 3 read without oe
  task automatic drv(input bit is_r, input int kind, input logic [AW-1:0] a,
                     input logic [7:0] d, input logic busy);
    if (!is_r) begin
      l_en = (kind != 0); l_we = (kind == 1); l_oe = (kind == 2);
      l_addr = a; l_wdata = d; l_busy = busy;
    end else begin
      r_en = (kind != 0); r_we = (kind == 1); r_oe = (kind == 2);
      r_addr = a; r_wdata = d; r_busy = busy;
    end
  endtask

  task automatic expect_rd(input bit is_r, input logic [7:0] d, input string tag);
    exp_t e;
    e.port = is_r; e.data = d; e.due = cyc + 1; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: pops scoreboard entries as the registered read data appears
  initial forever begin
    @(negedge clk);
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tag, e.port ? r_rdata : l_rdata, e.data);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 l_int_no", {7'd0, l_int_n}, 8'd1);
    chk("R1 r_int_no", {7'd0, r_int_n}, 8'd1);
    chk("R1 l_rdata", l_rdata, 8'h00);
    chk("R1 r_rdata", r_rdata, 8'h00);
    rst_ni = 1'b1;

    @(negedge clk);
    chk("R1 l_int_no after release", {7'd0, l_int_n}, 8'd1);
    drv(0, 1, 11'h010, 8'hA5, 0); drv(1, 1, 11'h020, 8'h3C, 0);
    @(negedge clk);
    drv(0, 2, 11'h020, 0, 0); expect_rd(0, 8'h3C, "R2 L reads R write");
    drv(1, 2, 11'h010, 0, 0); expect_rd(1, 8'hA5, "R2 R reads L write");
    @(negedge clk);
    drv(0, 2, 11'h010, 0, 0); expect_rd(0, 8'hA5, "R11 dual read L");
    drv(1, 2, 11'h010, 0, 0); expect_rd(1, 8'hA5, "R11 dual read R");
    @(negedge clk);
    drv(0, 1, 11'h010, 8'h77, 0);
    drv(1, 2, 11'h010, 0, 0); expect_rd(1, 8'hA5, "R11 read during write old");
    @(negedge clk);
    drv(0, 0, 0, 0, 0);
    drv(1, 2, 11'h010, 0, 0); expect_rd(1, 8'h77, "R2 new data");
    @(negedge clk);
    drv(0, 1, 11'h030, 8'h11, 0); drv(1, 1, 11'h030, 8'h22, 0);
    @(negedge clk);
    drv(0, 2, 11'h030, 0, 0); expect_rd(0, 8'h11, "R9 left wins L");
    drv(1, 2, 11'h030, 0, 0); expect_rd(1, 8'h11, "R9 left wins R");
    @(negedge clk);
    drv(0, 0, 0, 0, 0); drv(1, 0, 0, 0, 0);
    @(negedge clk);
    chk("R3 l_rdata hold", l_rdata, 8'h11);
    drv(1, 1, MBL, 8'hC3, 1);
    @(negedge clk);
    chk("R7 busy blocks set", {7'd0, l_int_n}, 8'd1);
    drv(1, 1, MBL, 8'hC3, 0);
    @(negedge clk);
    chk("R4 set l_int", {7'd0, l_int_n}, 8'd0);
    chk("R4 r_int untouched", {7'd0, r_int_n}, 8'd1);
    drv(1, 0, 0, 0, 0);
    drv(0, 3, MBL, 0, 0); expect_rd(0, 8'hC3, "R10 mailbox data");
    @(negedge clk);
    chk("R10 no clear without oe", {7'd0, l_int_n}, 8'd0);
    drv(0, 2, MBL, 0, 1); expect_rd(0, 8'hC3, "R7 busy read data");
    @(negedge clk);
    chk("R7 busy blocks clear", {7'd0, l_int_n}, 8'd0);
    drv(0, 2, MBL, 0, 0); expect_rd(0, 8'hC3, "R5 clear read data");
    @(negedge clk);
    chk("R5 clear l_int", {7'd0, l_int_n}, 8'd1);
    drv(0, 1, MBR, 8'h5A, 0);
    @(negedge clk);
    chk("R6 set r_int", {7'd0, r_int_n}, 8'd0);
    chk("R6 l_int untouched", {7'd0, l_int_n}, 8'd1);
    drv(0, 0, 0, 0, 0);
    drv(1, 2, MBR, 0, 0); expect_rd(1, 8'h5A, "R6 message");
    @(negedge clk);
    chk("R6 clear r_int", {7'd0, r_int_n}, 8'd1);
    drv(1, 1, MBL, 8'h99, 0);
    @(negedge clk);
    chk("R4 set again", {7'd0, l_int_n}, 8'd0);
    drv(0, 2, MBL, 0, 0); expect_rd(0, 8'h99, "R8 old message");
    drv(1, 1, MBL, 8'h44, 0);
    @(negedge clk);
    chk("R8 set wins", {7'd0, l_int_n}, 8'd0);
    drv(1, 0, 0, 0, 0);
    drv(0, 2, MBL, 0, 0); expect_rd(0, 8'h44, "R10 new message");
    @(negedge clk);
    chk("R5 clear after R8", {7'd0, l_int_n}, 8'd1);
    drv(0, 1, MBR, 8'h66, 1);
    @(negedge clk);
    chk("R7 busy blocks r set", {7'd0, r_int_n}, 8'd1);
    drv(0, 0, 0, 0, 0);
    drv(1, 2, MBR, 0, 0); expect_rd(1, 8'h66, "R7 busy write stored");
    @(negedge clk);
    drv(1, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule